// File: doc/BRIEF.md
# Prefix Window Remap and Page Key Tracker

This block sits right after address translation. Every real address that comes out of it passes through here. The block first exchanges two 8 KB windows of the address space: the one at address zero and the one that starts at a programmable, 8 KB-aligned prefix base. The result is the absolute address. The exchange is applied to every request, whether or not the request was translated.

Each absolute address that falls inside installed storage then marks its 4 KB page in an internal key array. A read grant sets the page's referenced bit, and a write grant sets its changed bit. A synchronous clear empties the whole array in one cycle. A registered inspection port returns the two bits of any page one cycle after it is asked.

Top module: `prefix_key_tracker`

## Requirements
- R1: A real address whose bits above bit 12 are all zero (below 0x2000) maps to the aligned prefix base plus the address. The low 13 bits of the prefix input are ignored.
- R2: When R1 does not apply, a real address whose bits above bit 12 equal those of the prefix base maps to the address minus the aligned prefix base, which lands in 0x0000 to 0x1FFF.
- R3: Every other real address passes through unchanged. With a prefix base of zero, every address is unchanged.
- R4: `absValid` rises in the cycle after `reqValid` is sampled high and is low otherwise. `absAddr` is registered on each request and holds its value while no request is sampled.
- R5: A request marks its page only if its absolute address is less than or equal to `memSize` and its page number fits in the key array. Otherwise the array is left untouched.
- R6: The page number is the absolute address shifted right by 12. A read grant sets that page's referenced bit, and a write grant sets its changed bit.
- R7: Key bits are only ever set by requests. A later request with fewer grants, or with none, leaves bits that are already set in place.
- R8: `keyClear` zeroes every page's two bits at the next edge. A request sampled in the same cycle as the clear leaves no mark.
- R9: When `keyRdEn` is sampled high, `keyRdRef`/`keyRdChg` show page `keyRdIdx` after that edge. The value is the state before any update made at the same edge. The outputs hold while `keyRdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Real address request strobe |
| realAddr | input | ADDR_W | Real address after translation |
| rdGrant | input | 1 | Read permission granted for this access |
| wrGrant | input | 1 | Write permission granted for this access |
| prefixBase | input | ADDR_W | Prefix base; the low 13 bits are ignored |
| memSize | input | ADDR_W | Highest absolute address of installed storage |
| keyClear | input | 1 | Clear all key bits |
| keyRdEn | input | 1 | Key inspection request |
| keyRdIdx | input | IDX_W | Page number to inspect |
| absAddr | output | ADDR_W | Registered absolute address |
| absValid | output | 1 | absAddr is fresh this cycle |
| keyRdRef | output | 1 | Referenced bit of the inspected page |
| keyRdChg | output | 1 | Changed bit of the inspected page |

## Verification
Two pairs of functions can meet on one edge. The first pair is a key update and a key clear. The bench issues a granted request and `keyClear` in the same cycle, then inspects that page and expects zero. The second pair is an inspection and an update of the same page. The bench raises `keyRdEn` together with a request that hits the inspected page, expects the old bits back, and expects the new bits on a second inspection.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic capture;   // register a new absolute address
    logic write;     // mark the selected page
    logic setRef;    // OR in the referenced bit
    logic setChg;    // OR in the changed bit
    logic clearAll;  // wipe the key array
    logic readOut;   // load the inspection registers
  } keyStrobe_t;

  localparam int WIN_BITS  = 13;  // 8 KB swap window
  localparam int PAGE_BITS = 12;  // 4 KB key granule

endpackage

// File: rtl/pkt_remap.sv
module pkt_remap
  import pkt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] realAddr,
  input  logic [ADDR_W-1:0] prefixBase,
  output logic [ADDR_W-1:0] absAddr
);

  localparam int HI_W = ADDR_W - WIN_BITS;

  logic [HI_W-1:0]     realHi;
  logic [HI_W-1:0]     pfxHi;
  logic [WIN_BITS-1:0] winOffset;
  logic                inLowWin;
  logic                inPfxWin;
  logic                unusedPfxLow;

  assign realHi       = realAddr[ADDR_W-1:WIN_BITS];
  assign pfxHi        = prefixBase[ADDR_W-1:WIN_BITS];
  assign winOffset    = realAddr[WIN_BITS-1:0];
  assign unusedPfxLow = ^prefixBase[WIN_BITS-1:0];

  assign inLowWin = (realHi == '0);
  assign inPfxWin = (realHi == pfxHi);

  // Because the base is window-aligned, add and subtract reduce to
  // replacing the upper bits.
  always_comb begin
    if (inLowWin)      absAddr = {pfxHi, winOffset};
    else if (inPfxWin) absAddr = {{HI_W{1'b0}}, winOffset};
    else               absAddr = realAddr;
  end

endmodule

// File: rtl/pkt_ctrl.sv
module pkt_ctrl
  import pkt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_PAGES = 64
) (
  input  logic              reqValid,
  input  logic              rdGrant,
  input  logic              wrGrant,
  input  logic [ADDR_W-1:0] absAddr,
  input  logic [ADDR_W-1:0] memSize,
  input  logic              keyClear,
  input  logic              keyRdEn,
  output keyStrobe_t        strobe,
  output logic [$clog2(NUM_PAGES)-1:0] wrIdx
);

  localparam int IDX_W   = $clog2(NUM_PAGES);
  localparam int FIT_LSB = PAGE_BITS + IDX_W;

  logic withinStorage;
  logic withinArray;

  assign withinStorage = (absAddr <= memSize);
  assign withinArray   = (absAddr[ADDR_W-1:FIT_LSB] == '0);
  assign wrIdx         = absAddr[PAGE_BITS +: IDX_W];

  always_comb begin
    strobe          = '0;
    strobe.capture  = reqValid;
    strobe.clearAll = keyClear;
    strobe.readOut  = keyRdEn;
    strobe.setRef   = rdGrant;
    strobe.setChg   = wrGrant;
    strobe.write    = reqValid && withinStorage && withinArray && !keyClear;
  end

endmodule

// File: rtl/pkt_datapath.sv
module pkt_datapath
  import pkt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_PAGES = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  keyStrobe_t                   strobe,
  input  logic [ADDR_W-1:0]            absIn,
  input  logic [$clog2(NUM_PAGES)-1:0] wrIdx,
  input  logic [$clog2(NUM_PAGES)-1:0] rdIdx,
  output logic [ADDR_W-1:0]            absOut,
  output logic                         absValid,
  output logic                         rdRef,
  output logic                         rdChg
);

  logic [NUM_PAGES-1:0] refArr;
  logic [NUM_PAGES-1:0] chgArr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      absOut   <= '0;
      absValid <= 1'b0;
      rdRef    <= 1'b0;
      rdChg    <= 1'b0;
    end else begin
      absValid <= strobe.capture;
      if (strobe.capture) absOut <= absIn;
      if (strobe.readOut) begin
        rdRef <= refArr[rdIdx];
        rdChg <= chgArr[rdIdx];
      end
    end
  end

  for (genvar gi = 0; gi < NUM_PAGES; gi++) begin : g_key
    logic hit;
    assign hit = strobe.write && (wrIdx == gi);

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearAll) begin
        refArr[gi] <= 1'b0;
        chgArr[gi] <= 1'b0;
      end else if (hit) begin
        refArr[gi] <= refArr[gi] | strobe.setRef;
        chgArr[gi] <= chgArr[gi] | strobe.setChg;
      end
    end

    // R7
    sticky_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
      (refArr[gi] && !strobe.clearAll) |=> refArr[gi]);
    // R7
    sticky_chg_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chgArr[gi] && !strobe.clearAll) |=> chgArr[gi]);
    // R6
    ref_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!refArr[gi] && !(strobe.write && strobe.setRef && wrIdx == gi)) |=> !refArr[gi]);
  end

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (refArr == '0 && chgArr == '0));
  // R4
  abs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(absOut));

endmodule

// File: rtl/prefix_key_tracker.sv
module prefix_key_tracker
  import pkt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_PAGES = 64,
  localparam int IDX_W    = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] realAddr,
  input  logic              rdGrant,
  input  logic              wrGrant,
  input  logic [ADDR_W-1:0] prefixBase,
  input  logic [ADDR_W-1:0] memSize,
  input  logic              keyClear,
  input  logic              keyRdEn,
  input  logic [IDX_W-1:0]  keyRdIdx,
  output logic [ADDR_W-1:0] absAddr,
  output logic              absValid,
  output logic              keyRdRef,
  output logic              keyRdChg
);

  logic [ADDR_W-1:0] absComb;
  logic [IDX_W-1:0]  pageIdx;
  keyStrobe_t        strobe;

  pkt_remap #(.ADDR_W(ADDR_W)) u_remap (
    .realAddr   (realAddr),
    .prefixBase (prefixBase),
    .absAddr    (absComb)
  );

  pkt_ctrl #(.ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES)) u_ctrl (
    .reqValid (reqValid),
    .rdGrant  (rdGrant),
    .wrGrant  (wrGrant),
    .absAddr  (absComb),
    .memSize  (memSize),
    .keyClear (keyClear),
    .keyRdEn  (keyRdEn),
    .strobe   (strobe),
    .wrIdx    (pageIdx)
  );

  pkt_datapath #(.ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .absIn    (absComb),
    .wrIdx    (pageIdx),
    .rdIdx    (keyRdIdx),
    .absOut   (absAddr),
    .absValid (absValid),
    .rdRef    (keyRdRef),
    .rdChg    (keyRdChg)
  );

  // R1
  low_to_prefix_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && realAddr[ADDR_W-1:WIN_BITS] == '0)
      |=> absAddr[ADDR_W-1:WIN_BITS] == $past(prefixBase[ADDR_W-1:WIN_BITS]));
  // R2
  prefix_to_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && realAddr[ADDR_W-1:WIN_BITS] != '0
      && realAddr[ADDR_W-1:WIN_BITS] == prefixBase[ADDR_W-1:WIN_BITS])
      |=> absAddr[ADDR_W-1:WIN_BITS] == '0);
  // R4
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> absValid);

endmodule

// File: tb/prefix_key_tracker_bench.sv
module prefix_key_tracker_bench;

  localparam int ADDR_W = 32;
  localparam int NPG    = 64;
  localparam int IW     = $clog2(NPG);

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [ADDR_W-1:0] realAddr;
  logic              rdGrant;
  logic              wrGrant;
  logic [ADDR_W-1:0] prefixBase;
  logic [ADDR_W-1:0] memSize;
  logic              keyClear;
  logic              keyRdEn;
  logic [IW-1:0]     keyRdIdx;
  logic [ADDR_W-1:0] absAddr;
  logic              absValid;
  logic              keyRdRef;
  logic              keyRdChg;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prefix_key_tracker #(.ADDR_W(ADDR_W), .NUM_PAGES(NPG)) u_prefix_key_tracker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .realAddr(realAddr),
    .rdGrant(rdGrant), .wrGrant(wrGrant), .prefixBase(prefixBase),
    .memSize(memSize), .keyClear(keyClear), .keyRdEn(keyRdEn),
    .keyRdIdx(keyRdIdx), .absAddr(absAddr), .absValid(absValid),
    .keyRdRef(keyRdRef), .keyRdChg(keyRdChg)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 0; keyClear = 0; keyRdEn = 0; rdGrant = 0; wrGrant = 0;
  endtask

  // One request; checks the registered absolute address.
  task automatic access(string req, logic [31:0] ra, bit rd, bit wr, logic [31:0] expAbs);
    @(negedge clk);
    reqValid = 1; realAddr = ra; rdGrant = rd; wrGrant = wr;
    @(posedge clk); #1;
    check(req, absValid, 1'b1);
    check(req, absAddr, expAbs);
    idle();
  endtask

  task automatic inspect(string req, int idx, bit expRef, bit expChg);
    @(negedge clk);
    keyRdEn = 1; keyRdIdx = IW'(idx);
    @(posedge clk); #1;
    check(req, {keyRdRef, keyRdChg}, {expRef, expChg});
    idle();
  endtask

  task automatic t_reset();
    check("R4 reset valid", absValid, 0);
    inspect("R9 reset key", 6, 0, 0);
  endtask

  task automatic t_remap();
    prefixBase = 32'h0000_7FFF;  // aligned base 0x6000, junk low bits
    access("R1 low window", 32'h0000_0123, 0, 0, 32'h0000_6123);
    access("R1 low top", 32'h0000_1FFF, 0, 0, 32'h0000_7FFF);
    access("R2 prefix window", 32'h0000_7456, 0, 0, 32'h0000_1456);
    access("R2 prefix base", 32'h0000_6000, 0, 0, 32'h0000_0000);
    access("R3 below prefix", 32'h0000_5FFF, 0, 0, 32'h0000_5FFF);
    access("R3 above prefix", 32'h0000_8000, 0, 0, 32'h0000_8000);
    access("R3 high", 32'hABCD_0000, 0, 0, 32'hABCD_0000);
    prefixBase = 0;
    access("R3 zero prefix", 32'h0000_1234, 0, 0, 32'h0000_1234);
    prefixBase = 32'h0000_6000;
  endtask

  task automatic t_hold();
    @(negedge clk); @(posedge clk); #1;
    check("R4 valid low when idle", absValid, 0);
    check("R4 address held", absAddr, 32'h0000_1234);
  endtask

  task automatic t_marks();
    access("R6 read mark", 32'h0000_0010, 1, 0, 32'h0000_6010);
    inspect("R6 page6 ref", 6, 1, 0);
    inspect("R6 page0 untouched", 0, 0, 0);
    access("R6 write mark", 32'h0000_0020, 0, 1, 32'h0000_6020);
    inspect("R6 page6 both", 6, 1, 1);
    access("R7 no grants", 32'h0000_0030, 0, 0, 32'h0000_6030);
    inspect("R7 bits kept", 6, 1, 1);
    access("R6 page 9 write", 32'h0000_9000, 0, 1, 32'h0000_9000);
    inspect("R6 page9 chg only", 9, 0, 1);
  endtask

  task automatic t_limit();
    memSize = 32'h0001_FFFF;
    access("R5 above size", 32'h0002_0000, 1, 1, 32'h0002_0000);
    inspect("R5 page32 untouched", 32, 0, 0);
    access("R5 at size", 32'h0001_FFFF, 1, 0, 32'h0001_FFFF);
    inspect("R5 page31 marked", 31, 1, 0);
    memSize = 32'hFFFF_FFFF;
    access("R5 beyond array", 32'h0004_0000, 1, 1, 32'h0004_0000);
    inspect("R5 alias page0 untouched", 0, 0, 0);
  endtask

  task automatic t_read_collide();
    @(negedge clk);
    reqValid = 1; realAddr = 32'h0000_C000; rdGrant = 1; wrGrant = 0;
    keyRdEn = 1; keyRdIdx = 12;
    @(posedge clk); #1;
    check("R9 same-edge old value", {keyRdRef, keyRdChg}, 2'b00);
    idle();
    @(negedge clk); @(posedge clk); #1;
    check("R9 holds when idle", {keyRdRef, keyRdChg}, 2'b00);
    inspect("R9 new value", 12, 1, 0);
  endtask

  task automatic t_clear();
    @(negedge clk);
    keyClear = 1; reqValid = 1; realAddr = 32'h0000_3000; rdGrant = 1; wrGrant = 1;
    @(posedge clk); #1;
    idle();
    inspect("R8 colliding update dropped", 3, 0, 0);
    inspect("R8 page6 cleared", 6, 0, 0);
    inspect("R8 page12 cleared", 12, 0, 0);
  endtask

  initial begin
    rstN = 0; reqValid = 0; realAddr = 0; rdGrant = 0; wrGrant = 0;
    prefixBase = 32'h0000_6000; memSize = 32'hFFFF_FFFF;
    keyClear = 0; keyRdEn = 0; keyRdIdx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    t_reset();
    t_remap();
    t_hold();
    t_marks();
    t_limit();
    t_read_collide();
    t_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule